// File: doc/BRIEF.md
# DRAM Strobe Decode and I/O Control

This block is the control logic of an asynchronous-style dynamic memory, modelled as a synchronous block that samples its strobes once per clock. It reads a row strobe, one column strobe per byte lane, a write-enable and an output-enable. From these it forms an internal column strobe, sorts each memory cycle into one of eight kinds and keeps a refresh row counter. It also drives per-lane read data, per-lane output enables and per-lane write strobes. A small behavioural array sits outside the block on a plain read/write port: the row, a combinational read column and the returned read data on one side, and a registered write column, write data and lane write strobes on the other.

All strobes are active low. The internal column strobe is low while any lane strobe is low. A row-strobe fall with the column strobe high opens an access to an external row. A row-strobe fall with the column strobe already low starts a refresh whose row comes from the internal counter. Read data follows extended-data-out rules: it stays on the lane after its strobe rises and is replaced only by the next column access.

Top module: `dram_strobe_ctl`

## Requirements
- R1: The internal column strobe falls with the first lane strobe and rises only after the last one. The column address is latched only at that first fall, so a lane that falls later in the same access reads the same column even if the address pins have changed.
- R2: A read drives a lane only if that lane's strobe fell during the access. Lane 0 carries data bits 7:0 and lane 1 carries bits 15:8. Lanes that stay high at a new column-strobe fall drop their old data.
- R3: A row-strobe fall with the column strobe low refreshes the row held in the internal counter and ignores the address pins. The counter then steps by one, and it reads zero after reset.
- R4: When the row strobe and the internal column strobe are both high, both lane output enables are off one clock later.
- R5: A lane is written on whichever comes later, its strobe fall or the write-enable fall, while the other is low and a row is open. The write strobe, data and column appear on the array port one clock later. No write strobe follows a clock where the row strobe is high.
- R6: A column-strobe fall with write-enable already low is an early write (cycle code 2), and the outputs stay off.
- R7: A write-enable fall while the column strobe is low gives one of two codes. If the outputs were driving read data it is a read-modify-write (code 4). Otherwise it is a late write (code 3).
- R8: Output-enable high turns the lane outputs off one clock later, and output-enable low again restores held data. A write-enable fall while the column strobe is low removes the held data.
- R9: A counter refresh that starts while read data is still held is a hidden refresh (code 7), and that data keeps driving through it. Without held data the refresh is code 6.
- R10: Every row-strobe fall gives a one-clock refresh pulse. With an external row it carries that row and sets code 5, which a later column access refines to read (1) or write.
- R11: Read data stays on a lane after the column strobe rises until the next column-strobe fall or until R4 applies.
- R12: After reset the cycle code is 0, the outputs and refresh pulse are off, and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | LANES | Per-lane column strobes, bit 0 = lane 0 |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero on lanes that are not driving |
| dq_oe | output | LANES | Per-lane output enable |
| cyc_type | output | 3 | Cycle code: 0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 external-row refresh, 6 counter refresh, 7 hidden refresh |
| ref_stb | output | 1 | One-clock pulse per row-strobe fall |
| ref_row | output | ADDR_W | Row refreshed by that pulse |
| mem_row | output | ADDR_W | Open row toward the array |
| mem_rd_col | output | ADDR_W | Read column toward the array (combinational) |
| mem_rdata | input | LANES*LANE_W | Array read data for mem_row/mem_rd_col |
| mem_wr_col | output | ADDR_W | Write column |
| mem_wdata | output | LANES*LANE_W | Write data |
| mem_wstb | output | LANES | Per-lane write strobe |

## Verification
Every registered result (output enables, read data, cycle code, refresh pulse and row, write strobes) is due one rising edge after the strobe change that causes it. The bench changes inputs on the falling edge and compares on the following falling edge. A write reaches the bench array one edge after the strobe and is stored on the edge after that, so the bench checks written data only through a read several clocks later. Refresh pulse checks sample in the clock right after the row-strobe fall and again one clock later, to confirm that the pulse lasts a single clock.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic [2:0] {
      CY_IDLE   = 3'd0,
      CY_READ   = 3'd1,
      CY_EWR    = 3'd2,
      CY_LWR    = 3'd3,
      CY_RMW    = 3'd4,
      CY_ROWREF = 3'd5,
      CY_CTRREF = 3'd6,
      CY_HIDDEN = 3'd7
   } cyc_e;

endpackage

// File: rtl/sdc_strobe.sv
module sdc_strobe #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_stb_n,
   input  logic [LANES-1:0] col_stb_n,
   input  logic             wr_en_n,
   output logic             cas_int,
   output logic             ras_fall,
   output logic             ras_rise,
   output logic             cas_fall,
   output logic             we_fall,
   output logic [LANES-1:0] lane_fall,
   output logic [LANES-1:0] lane_rise
);

   logic             ras_q;
   logic             cas_q;
   logic             we_q;
   logic [LANES-1:0] lane_q;

   // internal column strobe: low while any lane strobe is low
   assign cas_int  = &col_stb_n;
   assign ras_fall = ras_q & ~row_stb_n;
   assign ras_rise = ~ras_q & row_stb_n;
   assign cas_fall = cas_q & ~cas_int;
   assign we_fall  = we_q & ~wr_en_n;

   for (genvar g = 0; g < LANES; g++) begin : g_edge
      assign lane_fall[g] = lane_q[g] & ~col_stb_n[g];
      assign lane_rise[g] = ~lane_q[g] & col_stb_n[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q  <= 1'b1;
         cas_q  <= 1'b1;
         we_q   <= 1'b1;
         lane_q <= '1;
      end else begin
         ras_q  <= row_stb_n;
         cas_q  <= cas_int;
         we_q   <= wr_en_n;
         lane_q <= col_stb_n;
      end
   end

endmodule

// File: rtl/sdc_cycle.sv
module sdc_cycle
   import sdc_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int RC_W   = 9,
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    row_stb_n,
   input  logic [LANES-1:0]        col_stb_n,
   input  logic                    wr_en_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   input  logic                    cas_int,
   input  logic                    ras_fall,
   input  logic                    ras_rise,
   input  logic                    cas_fall,
   input  logic                    we_fall,
   input  logic [LANES-1:0]        lane_fall,
   input  logic                    any_lv,
   input  logic                    drv_any,
   output logic [LANES-1:0]        rd_ev,
   output logic [LANES-1:0]        wr_ev,
   output logic [2:0]              cyc_type,
   output logic                    ref_stb,
   output logic [ADDR_W-1:0]       ref_row,
   output logic [ADDR_W-1:0]       mem_row,
   output logic [ADDR_W-1:0]       mem_rd_col,
   output logic [ADDR_W-1:0]       mem_wr_col,
   output logic [LANES*LANE_W-1:0] mem_wdata,
   output logic [LANES-1:0]        mem_wstb
);

   localparam int DW = LANES * LANE_W;

   logic              acc_q;
   logic              acc_ok;
   logic [ADDR_W-1:0] row_q;
   logic [ADDR_W-1:0] col_q;
   logic [RC_W-1:0]   cnt_q;
   cyc_e              typ_q;
   logic              ref_stb_q;
   logic [ADDR_W-1:0] ref_row_q;
   logic [LANES-1:0]  wstb_q;
   logic [DW-1:0]     wdata_q;
   logic [ADDR_W-1:0] wcol_q;
   logic [ADDR_W-1:0] col_now;

   // a row is open and the row strobe is still low
   assign acc_ok  = acc_q & ~row_stb_n;
   assign col_now = (acc_ok && cas_fall) ? addr : col_q;

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         rd_ev[i] = acc_ok & lane_fall[i] & wr_en_n;
         wr_ev[i] = acc_ok & ((lane_fall[i] & ~wr_en_n) | (we_fall & ~col_stb_n[i]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= 1'b0;
         row_q     <= '0;
         col_q     <= '0;
         cnt_q     <= '0;
         typ_q     <= CY_IDLE;
         ref_stb_q <= 1'b0;
         ref_row_q <= '0;
         wstb_q    <= '0;
         wdata_q   <= '0;
         wcol_q    <= '0;
      end else begin
         ref_stb_q <= ras_fall;
         wstb_q    <= wr_ev;
         wdata_q   <= din;
         wcol_q    <= col_now;
         if (ras_fall) begin
            if (!cas_int) begin
               ref_row_q <= ADDR_W'(cnt_q);
               cnt_q     <= cnt_q + RC_W'(1);
               acc_q     <= 1'b0;
               typ_q     <= any_lv ? CY_HIDDEN : CY_CTRREF;
            end else begin
               ref_row_q <= addr;
               row_q     <= addr;
               acc_q     <= 1'b1;
               typ_q     <= CY_ROWREF;
            end
         end else begin
            if (ras_rise) acc_q <= 1'b0;
            if (acc_ok && cas_fall) begin
               col_q <= addr;
               typ_q <= wr_en_n ? CY_READ : CY_EWR;
            end else if (acc_ok && we_fall && !cas_int) begin
               typ_q <= drv_any ? CY_RMW : CY_LWR;
            end
         end
      end
   end

   assign cyc_type   = typ_q;
   assign ref_stb    = ref_stb_q;
   assign ref_row    = ref_row_q;
   assign mem_row    = row_q;
   assign mem_rd_col = col_now;
   assign mem_wr_col = wcol_q;
   assign mem_wdata  = wdata_q;
   assign mem_wstb   = wstb_q;

   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !cas_int) |=> (cnt_q == $past(cnt_q) + RC_W'(1))); // R3
   AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb_q |=> !ref_stb_q); // R10
   AST_ROW_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && cas_int) |=> (ref_row_q == $past(addr))); // R10
   AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      row_stb_n |=> (wstb_q == '0)); // R5

endmodule

// File: rtl/sdc_lane.sv
module sdc_lane #(
   parameter int LANE_W    = 8,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_ev,
   input  logic              wr_ev,
   input  logic [LANE_W-1:0] rdata_byte,
   input  logic              lane_n,
   input  logic              lane_rise,
   input  logic              cas_fall,
   input  logic              we_fall,
   input  logic              cas_int,
   input  logic              row_stb_n,
   input  logic              wr_en_n,
   input  logic              out_en_n,
   output logic              lv,
   output logic              oe_q,
   output logic [LANE_W-1:0] dq_byte
);

   logic              lv_q;
   logic              lv_d;
   logic [LANE_W-1:0] byte_q;
   logic [LANE_W-1:0] byte_d;
   logic              drop;

   // data is dropped by a write, by a new column access this lane skips,
   // by the write-enable disable, by full precharge, or (without hold) on
   // the lane's own strobe rise
   assign drop = wr_ev
               | (cas_fall & lane_n)
               | (we_fall & ~cas_int)
               | (row_stb_n & cas_int)
               | (!HOLD_DATA && lane_rise);

   always_comb begin
      lv_d   = lv_q;
      byte_d = byte_q;
      if (rd_ev) begin
         lv_d   = 1'b1;
         byte_d = rdata_byte;
      end else if (drop) begin
         lv_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv_q   <= 1'b0;
         byte_q <= '0;
         oe_q   <= 1'b0;
      end else begin
         lv_q   <= lv_d;
         byte_q <= byte_d;
         oe_q   <= lv_d & ~out_en_n;
      end
   end

   assign lv      = lv_q;
   assign dq_byte = oe_q ? byte_q : '0;

   AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (row_stb_n && cas_int) |=> !oe_q); // R4
   AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |=> !oe_q); // R8
   AST_WE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_n && !cas_int) |=> !oe_q); // R8

endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
   parameter int ADDR_W    = 9,
   parameter int RC_W      = 9,
   parameter int LANES     = 2,
   parameter int LANE_W    = 8,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    row_stb_n,
   input  logic [LANES-1:0]        col_stb_n,
   input  logic                    wr_en_n,
   input  logic                    out_en_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic [LANES-1:0]        dq_oe,
   output logic [2:0]              cyc_type,
   output logic                    ref_stb,
   output logic [ADDR_W-1:0]       ref_row,
   output logic [ADDR_W-1:0]       mem_row,
   output logic [ADDR_W-1:0]       mem_rd_col,
   input  logic [LANES*LANE_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0]       mem_wr_col,
   output logic [LANES*LANE_W-1:0] mem_wdata,
   output logic [LANES-1:0]        mem_wstb
);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (RC_W < 1 || RC_W > ADDR_W) begin : g_bad_rc
      $error("RC_W must lie between 1 and ADDR_W");
   end
   if (LANE_W < 1) begin : g_bad_lw
      $error("LANE_W must be at least 1");
   end

   logic             cas_int;
   logic             ras_fall;
   logic             ras_rise;
   logic             cas_fall;
   logic             we_fall;
   logic [LANES-1:0] lane_fall;
   logic [LANES-1:0] lane_rise;
   logic [LANES-1:0] rd_ev;
   logic [LANES-1:0] wr_ev;
   logic [LANES-1:0] lv_vec;

   sdc_strobe #(.LANES(LANES)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_stb_n (row_stb_n),
      .col_stb_n (col_stb_n),
      .wr_en_n   (wr_en_n),
      .cas_int   (cas_int),
      .ras_fall  (ras_fall),
      .ras_rise  (ras_rise),
      .cas_fall  (cas_fall),
      .we_fall   (we_fall),
      .lane_fall (lane_fall),
      .lane_rise (lane_rise)
   );

   sdc_cycle #(
      .ADDR_W (ADDR_W),
      .RC_W   (RC_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_cycle (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_stb_n  (row_stb_n),
      .col_stb_n  (col_stb_n),
      .wr_en_n    (wr_en_n),
      .addr       (addr),
      .din        (din),
      .cas_int    (cas_int),
      .ras_fall   (ras_fall),
      .ras_rise   (ras_rise),
      .cas_fall   (cas_fall),
      .we_fall    (we_fall),
      .lane_fall  (lane_fall),
      .any_lv     (|lv_vec),
      .drv_any    (|dq_oe),
      .rd_ev      (rd_ev),
      .wr_ev      (wr_ev),
      .cyc_type   (cyc_type),
      .ref_stb    (ref_stb),
      .ref_row    (ref_row),
      .mem_row    (mem_row),
      .mem_rd_col (mem_rd_col),
      .mem_wr_col (mem_wr_col),
      .mem_wdata  (mem_wdata),
      .mem_wstb   (mem_wstb)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sdc_lane #(
         .LANE_W    (LANE_W),
         .HOLD_DATA (HOLD_DATA)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .rd_ev      (rd_ev[g]),
         .wr_ev      (wr_ev[g]),
         .rdata_byte (mem_rdata[g*LANE_W +: LANE_W]),
         .lane_n     (col_stb_n[g]),
         .lane_rise  (lane_rise[g]),
         .cas_fall   (cas_fall),
         .we_fall    (we_fall),
         .cas_int    (cas_int),
         .row_stb_n  (row_stb_n),
         .wr_en_n    (wr_en_n),
         .out_en_n   (out_en_n),
         .lv         (lv_vec[g]),
         .oe_q       (dq_oe[g]),
         .dq_byte    (dq_out[g*LANE_W +: LANE_W])
      );
   end

endmodule

// File: tb/dram_strobe_ctl_bench.sv
`timescale 1ns/1ps
module dram_strobe_ctl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        row_stb_n = 1'b1;
   logic [1:0]  col_stb_n = 2'b11;
   logic        wr_en_n = 1'b1;
   logic        out_en_n = 1'b1;
   logic [8:0]  addr = '0;
   logic [15:0] din = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;
   logic [2:0]  cyc_type;
   logic        ref_stb;
   logic [8:0]  ref_row;
   logic [8:0]  mem_row;
   logic [8:0]  mem_rd_col;
   logic [15:0] mem_rdata;
   logic [8:0]  mem_wr_col;
   logic [15:0] mem_wdata;
   logic [1:0]  mem_wstb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] mem [64];

   always #2.5 clk = ~clk;

   dram_strobe_ctl u_dram_strobe_ctl (
      .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
      .wr_en_n(wr_en_n), .out_en_n(out_en_n), .addr(addr), .din(din),
      .dq_out(dq_out), .dq_oe(dq_oe), .cyc_type(cyc_type), .ref_stb(ref_stb),
      .ref_row(ref_row), .mem_row(mem_row), .mem_rd_col(mem_rd_col),
      .mem_rdata(mem_rdata), .mem_wr_col(mem_wr_col), .mem_wdata(mem_wdata),
      .mem_wstb(mem_wstb)
   );

   // behavioural array: 8 rows x 8 columns
   assign mem_rdata = mem[{mem_row[2:0], mem_rd_col[2:0]}];

   always @(posedge clk) begin
      for (int l = 0; l < 2; l++)
         if (mem_wstb[l]) mem[{mem_row[2:0], mem_wr_col[2:0]}][l*8 +: 8] <= mem_wdata[l*8 +: 8];
   end

   // vector: {ctl(ras,lane0,lane1,we,oe), addr, din, exp_oe, exp_dq, exp_type, req}
   function automatic logic [54:0] v(input logic [4:0] c, input logic [8:0] a,
                                     input logic [15:0] d, input logic [1:0] eo,
                                     input logic [15:0] eq, input logic [2:0] et,
                                     input logic [3:0] rq);
      return {c, a, d, eo, eq, et, rq};
   endfunction

   localparam int NV = 30;
   localparam logic [54:0] TBL [NV] = '{
      v(5'b11111, 9'd0, 16'h0000, 2'b00, 16'h0000, 3'd0, 4'd12), // R12 idle
      v(5'b01110, 9'd1, 16'h0000, 2'b00, 16'h0000, 3'd5, 4'd10), // R10 row open
      v(5'b00010, 9'd2, 16'h0000, 2'b11, 16'h4A0A, 3'd1, 4'd2),  // R2 word read
      v(5'b01110, 9'd3, 16'h0000, 2'b11, 16'h4A0A, 3'd1, 4'd11), // R11 hold after rise
      v(5'b00110, 9'd3, 16'h0000, 2'b01, 16'h000B, 3'd1, 4'd2),  // R2 lower lane only
      v(5'b00010, 9'd5, 16'h0000, 2'b11, 16'h4B0B, 3'd1, 4'd1),  // R1 late lane, old column
      v(5'b00011, 9'd5, 16'h0000, 2'b00, 16'h0000, 3'd1, 4'd8),  // R8 OE high
      v(5'b00010, 9'd5, 16'h0000, 2'b11, 16'h4B0B, 3'd1, 4'd8),  // R8 OE low again
      v(5'b00000, 9'd5, 16'h1234, 2'b00, 16'h0000, 3'd4, 4'd7),  // R7 read-modify-write
      v(5'b01110, 9'd5, 16'h0000, 2'b00, 16'h0000, 3'd4, 4'd7),  // R7
      v(5'b11110, 9'd5, 16'h0000, 2'b00, 16'h0000, 3'd4, 4'd4),  // R4 precharge
      v(5'b01110, 9'd1, 16'h0000, 2'b00, 16'h0000, 3'd5, 4'd10), // R10
      v(5'b00010, 9'd3, 16'h0000, 2'b11, 16'h1234, 3'd1, 4'd5),  // R5 written word
      v(5'b01111, 9'd4, 16'h0000, 2'b00, 16'h0000, 3'd1, 4'd8),  // R8
      v(5'b00011, 9'd4, 16'h0000, 2'b00, 16'h0000, 3'd1, 4'd8),  // R8 read, OE high
      v(5'b00001, 9'd4, 16'hBEEF, 2'b00, 16'h0000, 3'd3, 4'd7),  // R7 late write
      v(5'b01110, 9'd4, 16'h0000, 2'b00, 16'h0000, 3'd3, 4'd7),  // R7
      v(5'b01100, 9'd4, 16'h0000, 2'b00, 16'h0000, 3'd3, 4'd5),  // R5 WE low, no strobe
      v(5'b00100, 9'd5, 16'h00C3, 2'b00, 16'h0000, 3'd2, 4'd6),  // R6 early write lane 0
      v(5'b01110, 9'd5, 16'h0000, 2'b00, 16'h0000, 3'd2, 4'd6),  // R6
      v(5'b00010, 9'd4, 16'h0000, 2'b11, 16'hBEEF, 3'd1, 4'd5),  // R5 late-write data
      v(5'b01110, 9'd4, 16'h0000, 2'b11, 16'hBEEF, 3'd1, 4'd11), // R11
      v(5'b00010, 9'd5, 16'h0000, 2'b11, 16'h4DC3, 3'd1, 4'd5),  // R5 byte write
      v(5'b10010, 9'd5, 16'h0000, 2'b11, 16'h4DC3, 3'd1, 4'd9),  // R9 row strobe up
      v(5'b00010, 9'd7, 16'h0000, 2'b11, 16'h4DC3, 3'd7, 4'd9),  // R9 hidden refresh
      v(5'b01110, 9'd7, 16'h0000, 2'b11, 16'h4DC3, 3'd7, 4'd11), // R11
      v(5'b11110, 9'd7, 16'h0000, 2'b00, 16'h0000, 3'd7, 4'd4),  // R4
      v(5'b10010, 9'd7, 16'h0000, 2'b00, 16'h0000, 3'd7, 4'd3),  // R3 strobe before row
      v(5'b00010, 9'd9, 16'h0000, 2'b00, 16'h0000, 3'd6, 4'd3),  // R3 counter refresh
      v(5'b11110, 9'd9, 16'h0000, 2'b00, 16'h0000, 3'd6, 4'd4)   // R4
   };

   task automatic apply(input logic [4:0] c, input logic [8:0] a, input logic [15:0] d);
      row_stb_n    = c[4];
      col_stb_n[0] = c[3];
      col_stb_n[1] = c[2];
      wr_en_n      = c[1];
      out_en_n     = c[0];
      addr         = a;
      din          = d;
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = {8'(i + 64), 8'(i)};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 reset", {27'd0, dq_oe, cyc_type}, {27'd0, 2'b00, 3'd0});
      chk("R12 reset ref", {22'd0, ref_stb, ref_row}, 32'd0);

      for (int k = 0; k < NV; k++) begin
         apply(TBL[k][54:50], TBL[k][49:41], TBL[k][40:25]);
         chk($sformatf("R%0d vector %0d", TBL[k][3:0], k),
             {11'd0, dq_oe, dq_out, cyc_type},
             {11'd0, TBL[k][24:23], TBL[k][22:7], TBL[k][6:4]});
      end

      // R3 counter refresh with address ignored: counter now at 2
      apply(5'b10011, 9'h0FF, 16'h0);
      apply(5'b00011, 9'h0FF, 16'h0);
      chk("R3 counter row", {22'd0, ref_stb, ref_row}, {22'd0, 1'b1, 9'd2});
      apply(5'b11111, 9'h0, 16'h0);
      chk("R3 pulse width", {31'd0, ref_stb}, 32'd0);
      // R10 external row refresh
      apply(5'b01111, 9'h1A5, 16'h0);
      chk("R10 external row", {19'd0, ref_stb, ref_row, cyc_type}, {19'd0, 1'b1, 9'h1A5, 3'd5});
      apply(5'b11111, 9'h0, 16'h0);
      chk("R10 pulse width", {31'd0, ref_stb}, 32'd0);
      // R3 counter unaffected by external row refresh
      apply(5'b10011, 9'h0, 16'h0);
      apply(5'b00011, 9'h0, 16'h0);
      chk("R3 counter step", {19'd0, ref_stb, ref_row, cyc_type}, {19'd0, 1'b1, 9'd3, 3'd6});
      apply(5'b11111, 9'h0, 16'h0);
      // R12 reset mid-run clears counter
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 after reset", {27'd0, dq_oe, cyc_type}, 32'd0);
      apply(5'b10011, 9'h0, 16'h0);
      apply(5'b00011, 9'h0, 16'h0);
      chk("R12 counter cleared", {22'd0, ref_stb, ref_row}, {22'd0, 1'b1, 9'd0});
      apply(5'b11111, 9'h0, 16'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule